// File: doc/BRIEF.md
# Fractional-Increment PWM Generator with Deferred Settings Update

This block produces one pulse-width-modulated output from a single 32-bit control word. A 16-bit phase accumulator advances by a programmable increment on every clock while the generator is enabled. The accumulator wraps modulo 65536, so the output period is 65536/increment clocks and the output frequency is the clock rate times increment/65536. The duty cycle comes from comparing the accumulator's upper byte with an on-time threshold. A larger threshold gives a shorter high time.

Software writes the whole control word. The increment and threshold fields land in shadow storage and do not change the waveform until the update-request bit is set. A pending request is applied at the next period boundary, and the hardware then clears the request bit. When disabled, the generator holds its output low and parks the accumulator at zero, so a re-enable starts a clean period. The control word can always be read back, which lets software update one field at a time with read-modify-write.

Top module: `pwm_phase_gen`

## Requirements
- R1: After reset, the control word reads as zero, no update is pending and the output is low.
- R2: A write stores the enable in bit 31, the update request in bit 30, the increment in bits 23:8 and the threshold in bits 7:0. From the clock after the write, a read returns these fields. Bits 29:24 read as zero.
- R3: While enabled, the accumulator starts at zero and advances by the active increment on each clock, modulo 65536. A carry out of bit 15 marks a period boundary.
- R4: While enabled, the output is high exactly when accumulator bits 15:8 are greater than or equal to the active threshold. It follows the accumulator in the same cycle, with no extra register stage.
- R5: While bit 31 is clear, the output is low and the accumulator is forced to zero on every clock.
- R6: A write that leaves bit 30 clear changes only the shadow fields. The waveform keeps using the active increment and threshold.
- R7: While enabled with a nonzero active increment, a pending request is applied on the clock edge where the accumulator wraps. The new threshold and increment govern the output from the next cycle, and bit 30 reads zero from then on.
- R8: A pending request is applied on the next clock edge if the generator is disabled or the active increment is zero, because no period boundary would otherwise arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Writes wr_data into the control word on this clock edge |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Current control word (shadow fields, enable, pending request) |
| pwm_out | output | 1 | PWM output |

## Verification
A write takes effect on the clock edge that samples it. Its readback and the enable both appear in the following cycle, and in that cycle the accumulator sits at zero as the period's first step. The output depends only on registered state with no extra stage, so the bench compares the value of cycle t of a period against ((t·increment) mod 65536)>>8 ≥ threshold, sampling at the falling edge. A request raised mid-period is checked in three places: the old threshold holds through the last pre-wrap cycle, the new one holds from the cycle after the wrap, and bit 30 drops in that same cycle. A request while disabled or stalled takes effect one cycle after it is written.

// File: rtl/pwm_phase_pkg.sv
package pwm_phase_pkg;
   localparam int CTRL_W  = 32;
   localparam int EN_POS  = 31;
   localparam int UPD_POS = 30;

   typedef enum logic [0:0] {
      OUT_COMB = 1'b0,
      OUT_FLOP = 1'b1
   } out_mode_e;
endpackage

// File: rtl/pwm_ctrl_reg.sv
module pwm_ctrl_reg
   import pwm_phase_pkg::*;
#(
   parameter int INC_W  = 16,
   parameter int DUTY_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [CTRL_W-1:0]   wr_data,
   input  logic                commit,
   output logic                en,
   output logic                upd,
   output logic [INC_W-1:0]    shd_inc,
   output logic [DUTY_W-1:0]   shd_duty,
   output logic [CTRL_W-1:0]   rd_data
);
   localparam int INC_LSB = DUTY_W;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en       <= 1'b0;
         upd      <= 1'b0;
         shd_inc  <= '0;
         shd_duty <= '0;
      end else if (wr_en) begin
         en       <= wr_data[EN_POS];
         upd      <= wr_data[UPD_POS];
         shd_inc  <= wr_data[INC_LSB +: INC_W];
         shd_duty <= wr_data[0 +: DUTY_W];
      end else if (commit) begin
         upd      <= 1'b0;
      end
   end

   always_comb begin
      rd_data                    = '0;
      rd_data[EN_POS]            = en;
      rd_data[UPD_POS]           = upd;
      rd_data[INC_LSB +: INC_W]  = shd_inc;
      rd_data[0 +: DUTY_W]       = shd_duty;
   end
endmodule

// File: rtl/pwm_active_regs.sv
module pwm_active_regs #(
   parameter int INC_W  = 16,
   parameter int DUTY_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              upd,
   input  logic              wrap,
   input  logic [INC_W-1:0]  shd_inc,
   input  logic [DUTY_W-1:0] shd_duty,
   output logic [INC_W-1:0]  act_inc,
   output logic [DUTY_W-1:0] act_duty,
   output logic              commit
);
   logic stalled;

   assign stalled = (act_inc == '0);
   assign commit  = upd & (~en | wrap | stalled);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_inc  <= '0;
         act_duty <= '0;
      end else if (commit) begin
         act_inc  <= shd_inc;
         act_duty <= shd_duty;
      end
   end
endmodule

// File: rtl/pwm_phase_acc.sv
module pwm_phase_acc #(
   parameter int ACC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [ACC_W-1:0] inc,
   output logic [ACC_W-1:0] acc,
   output logic             wrap
);
   logic [ACC_W:0] sum;

   assign sum  = {1'b0, acc} + {1'b0, inc};
   assign wrap = en & sum[ACC_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         acc <= '0;
      else if (en)
         acc <= sum[ACC_W-1:0];
      else
         acc <= '0;
   end
endmodule

// File: rtl/pwm_duty_cmp.sv
module pwm_duty_cmp
   import pwm_phase_pkg::*;
#(
   parameter int        ACC_W    = 16,
   parameter int        DUTY_W   = 8,
   parameter out_mode_e OUT_MODE = OUT_COMB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [ACC_W-1:0]  acc,
   input  logic [DUTY_W-1:0] duty,
   output logic              pwm
);
   logic level;

   assign level = en & (acc[ACC_W-1 -: DUTY_W] >= duty);

   if (OUT_MODE == OUT_FLOP) begin : g_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pwm <= 1'b0;
         else        pwm <= level;
      end
   end else begin : g_comb
      assign pwm = level;
   end
endmodule

// File: rtl/pwm_phase_gen.sv
module pwm_phase_gen
   import pwm_phase_pkg::*;
#(
   parameter int        ACC_W    = 16,
   parameter int        DUTY_W   = 8,
   parameter out_mode_e OUT_MODE = OUT_COMB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [31:0]       wr_data,
   output logic [31:0]       rd_data,
   output logic              pwm_out
);
   localparam int INC_W = ACC_W;

   if (DUTY_W > ACC_W) begin : g_bad_duty
      $error("threshold wider than accumulator");
   end
   if (INC_W + DUTY_W > UPD_POS) begin : g_bad_fit
      $error("fields overlap the control bits");
   end
   if (CTRL_W != 32) begin : g_bad_ctrl
      $error("control word must be 32 bits");
   end

   logic              en;
   logic              upd;
   logic              commit;
   logic              wrap;
   logic [INC_W-1:0]  shd_inc;
   logic [DUTY_W-1:0] shd_duty;
   logic [INC_W-1:0]  act_inc;
   logic [DUTY_W-1:0] act_duty;
   logic [ACC_W-1:0]  acc_q;

   pwm_ctrl_reg #(.INC_W(INC_W), .DUTY_W(DUTY_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .commit(commit), .en(en), .upd(upd), .shd_inc(shd_inc),
      .shd_duty(shd_duty), .rd_data(rd_data)
   );

   pwm_active_regs #(.INC_W(INC_W), .DUTY_W(DUTY_W)) u_act (
      .clk(clk), .rst_n(rst_n), .en(en), .upd(upd), .wrap(wrap),
      .shd_inc(shd_inc), .shd_duty(shd_duty), .act_inc(act_inc),
      .act_duty(act_duty), .commit(commit)
   );

   pwm_phase_acc #(.ACC_W(ACC_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .en(en), .inc(act_inc),
      .acc(acc_q), .wrap(wrap)
   );

   pwm_duty_cmp #(.ACC_W(ACC_W), .DUTY_W(DUTY_W), .OUT_MODE(OUT_MODE)) u_cmp (
      .clk(clk), .rst_n(rst_n), .en(en), .acc(acc_q), .duty(act_duty),
      .pwm(pwm_out)
   );
endmodule

// File: rtl/pwm_phase_chk.sv
module pwm_phase_chk
   import pwm_phase_pkg::*;
#(
   parameter int        ACC_W    = 16,
   parameter int        DUTY_W   = 8,
   parameter out_mode_e OUT_MODE = OUT_COMB
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [31:0]       wr_data,
   input logic [31:0]       rd_data,
   input logic              pwm_out,
   input logic [ACC_W-1:0]  acc_q,
   input logic [ACC_W-1:0]  act_inc,
   input logic              wrap
);
   localparam logic [31:0] RD_MASK =
      (32'h1 << EN_POS) | (32'h1 << UPD_POS) | ((32'h1 << (ACC_W + DUTY_W)) - 32'h1);

   // R2: readback equals the last written word with reserved bits cleared
   assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_en) |-> rd_data == ($past(wr_data) & RD_MASK));

   // R5: accumulator parked at zero after a disabled cycle
   assert_park_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_data[EN_POS] |=> acc_q == '0);

   if (OUT_MODE == OUT_COMB) begin : g_low_comb
      assert_off_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
         !rd_data[EN_POS] |-> !pwm_out);
   end else begin : g_low_flop
      assert_off_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
         !rd_data[EN_POS] |=> !pwm_out);
   end

   // R3: a boundary always moves the accumulator backwards
   assert_wrap_back_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> acc_q < $past(acc_q));

   // R6: active increment only moves while a request was pending
   assert_act_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(act_inc) |-> $past(rd_data[UPD_POS]));

   // R7 R8: request clears without a write only at an allowed point
   assert_clear_point_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(rd_data[UPD_POS]) && !$past(wr_en)) |->
         $past(wrap || !rd_data[EN_POS] || act_inc == '0));
endmodule

bind pwm_phase_gen pwm_phase_chk #(.ACC_W(ACC_W), .DUTY_W(DUTY_W), .OUT_MODE(OUT_MODE)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
   .rd_data(rd_data), .pwm_out(pwm_out), .acc_q(acc_q),
   .act_inc(act_inc), .wrap(wrap)
);

// File: tb/sim_pwm_phase_gen.sv
`timescale 1ns/1ps
module sim_pwm_phase_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        pwm_out;
   int          n_chk = 0;
   int          n_err = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   pwm_phase_gen u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .pwm_out(pwm_out)
   );

   function automatic logic [31:0] word(bit en, bit up, logic [15:0] inc, logic [7:0] duty);
      return {en, up, 6'b0, inc, duty};
   endfunction

   function automatic bit expect_lvl(longint t, logic [15:0] inc, logic [7:0] duty);
      longint a;
      a = (t * longint'(inc)) % 65536;
      return ((a >> 8) >= longint'(duty));
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // called at a falling edge; the write is taken at the next rising edge
   task automatic wr(logic [31:0] d);
      wr_en = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // load settings while disabled, then enable: returns at cycle t=0
   task automatic start_cfg(logic [15:0] inc, logic [7:0] duty);
      wr(word(0, 1, inc, duty));
      wr(word(1, 0, inc, duty));
   endtask

   task automatic run_cfg(string req, logic [15:0] inc, logic [7:0] duty, int n);
      int bad = 0;
      start_cfg(inc, duty);
      for (int t = 0; t < n; t++) begin
         if (pwm_out !== expect_lvl(t, inc, duty)) begin
            if (bad == 0)
               $display("  mismatch inc=%h duty=%h t=%0d", inc, duty, t);
            bad++;
         end
         @(negedge clk);
      end
      chk(req, bad, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_err++; n_chk++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [15:0] incs [5] = '{16'h0100, 16'h1000, 16'h2AAB, 16'h8000, 16'h8002};
      logic [7:0]  dutys[5] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF};
      int bad;

      repeat (3) @(negedge clk);
      chk("R1 rd_data", rd_data, 32'h0);
      chk("R1 pwm", {31'b0, pwm_out}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R8: stalled (zero increment) generator takes a request next edge
      wr(word(1, 0, 16'h0000, 8'h00));
      chk("R4 stalled high", {31'b0, pwm_out}, 32'h1);
      wr(word(1, 1, 16'h0000, 8'h10));
      chk("R8 pending", {31'b0, rd_data[30]}, 32'h1);
      chk("R8 old duty", {31'b0, pwm_out}, 32'h1);
      @(negedge clk);
      chk("R8 applied", {31'b0, pwm_out}, 32'h0);
      chk("R8 cleared", {31'b0, rd_data[30]}, 32'h0);

      // R5: disabled output stays low even with threshold zero
      wr(word(1, 1, 16'h0000, 8'h00));
      @(negedge clk);
      chk("R5 enabled high", {31'b0, pwm_out}, 32'h1);
      wr(word(0, 0, 16'h0000, 8'h00));
      bad = 0;
      for (int i = 0; i < 6; i++) begin
         if (pwm_out !== 1'b0) bad++;
         @(negedge clk);
      end
      chk("R5 held low", bad, 0);

      // R3 R4: sweep increments and thresholds from a fresh period
      foreach (incs[i])
         foreach (dutys[j])
            run_cfg("R3 R4 sweep", incs[i], dutys[j], 600);
      run_cfg("R5 restart from zero", 16'h4000, 8'h40, 9);

      // R2: readback, reserved bits dropped
      wr(32'hFFFF_FFFF);
      chk("R2 readback", rd_data, 32'hC0FF_FFFF);
      wr(word(0, 0, 16'h1234, 8'h56));
      chk("R2 fields", rd_data, 32'h0012_3456);

      // R6: shadow-only writes leave the waveform alone
      wr(word(0, 1, 16'h4000, 8'h80));
      wr(word(0, 0, 16'h1000, 8'hD0));
      wr(word(1, 0, 16'h1000, 8'hD0));
      bad = 0;
      for (int t = 0; t < 12; t++) begin
         if (pwm_out !== expect_lvl(t, 16'h4000, 8'h80)) bad++;
         @(negedge clk);
      end
      chk("R6 old waveform", bad, 0);
      chk("R6 shadow visible", {16'b0, rd_data[23:8]}, 32'h1000);

      // R7: request mid-period lands at the wrap
      start_cfg(16'h4000, 8'h80);
      chk("R7 t0", {31'b0, pwm_out}, 32'h0);
      wr(word(1, 1, 16'h1000, 8'hD0));
      chk("R7 t1", {31'b0, pwm_out}, 32'h0);
      @(negedge clk);
      chk("R7 t2 old duty", {31'b0, pwm_out}, 32'h1);
      @(negedge clk);
      chk("R7 t3 old duty", {31'b0, pwm_out}, 32'h1);
      chk("R7 t3 pending", {31'b0, rd_data[30]}, 32'h1);
      @(negedge clk);
      chk("R7 t4 cleared", {31'b0, rd_data[30]}, 32'h0);
      bad = 0;
      for (int k = 0; k < 40; k++) begin
         if (pwm_out !== expect_lvl(k, 16'h1000, 8'hD0)) bad++;
         @(negedge clk);
      end
      chk("R7 new settings", bad, 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule